// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block sits on a CPU register bus and drives the pins of a raw 8-bit NAND flash device. Software controls the command-latch, address-latch and chip-enable pins by writing a mode register. It moves bytes by accessing a data window. Every data-window access produces exactly one read or write strobe. The strobe stays low for a programmable number of clock cycles, and the CPU is held by a wait signal until that strobe has finished.

The flash ready/busy pin is passed through a two-flop synchronizer. Its level is reported as a busy status bit. Any level change on the synchronized pin sets a sticky flag. That flag can drive an interrupt output through a mask bit and an enable bit. A two-bit ECC mode field is stored and decoded into an operation code, which is combined with chip enable. No ECC parity is generated, and the ECC code register reads zero. Writing the soft-reset register returns every control register to its reset value.

Top module: `nand_bus_ctrl`

## Requirements
- R1: A data-window access drives its strobe (`nand_we_n` for writes, `nand_re_n` for reads) low for exactly W+1 clock cycles. W is the 4-bit pulse register at index 5, bits [3:0]. The two strobes are never low together.
- R2: Bit 2 (chip enable) of the mode register at index 1 set to 1 drives `nand_ce_n` low. When the bit is 0, `nand_ce_n` is high.
- R3: Mode register bit 0 drives `nand_cle` and bit 1 drives `nand_ale`, with 1 giving a high pin.
- R4: `ecc_op` decodes mode bits [5:4] (E) together with the chip-enable bit (C). E=11 gives 3 (clear) for either value of C. With C=1: E=00 gives 0 (off), E=01 gives 1 (write ECC), E=10 gives 2 (read ECC). With C=0: E=10 gives 4 (ID read), and every other code gives 0.
- R5: A data-window write produces a write strobe only while mode bit 3 (write enable) is 1. When that bit is 0, the write causes no strobe and `bus_wait` stays low.
- R6: During a data-window access, `bus_wait` stays high from the first cycle of the access through the last strobe-low cycle, which is W+2 cycles. For a read, `bus_rdata` in the completing cycle holds `nand_io_in` as sampled on the last strobe-low cycle. For a write, `nand_io_out` holds the written byte and `nand_io_oe` is high while the strobe is low.
- R7: Status register (index 2) bit 0 reads 1 while the synchronized `nand_rb_n` is low (busy) and 0 when it is high (ready).
- R8: Interrupt flag register (index 3) bit 0 is set by any level change of the synchronized ready/busy pin. Writing 1 to it clears it. A change in the same cycle as the clear wins.
- R9: `irq` is high only when the flag is set, mask register (index 4) bit 0 is 1, and status bit 1 (interrupt enable) is 1.
- R10: Writing 1 to bit 0 of the reset register (index 6) clears the mode, interrupt-enable, flag, mask and pulse registers.
- R11: The ECC code register (index 7) and the reset register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request, held until `bus_wait` is low |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid when `bus_wait` is low |
| bus_wait | output | 1 | CPU stall during data-window strobes |
| nand_io_out | output | DATA_W | Byte driven to flash |
| nand_io_in | input | DATA_W | Byte read from flash |
| nand_io_oe | output | 1 | Output enable for the flash data pins |
| nand_ce_n | output | 1 | Active-low chip enable |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from flash |
| irq | output | 1 | Ready/busy change interrupt |
| ecc_op | output | 3 | Decoded ECC operation |

## Verification
Some properties are checked on every cycle: the length of each strobe against the pulse register, that the two strobes are never low together, that `bus_wait` is bounded, that a write strobe only follows a data-window write, that the latch and chip-enable pins follow mode writes, that the flag rises after each synchronized level change, and that the pins return to idle after a soft reset. Other behaviour can only be shown by the bench's scenarios. This covers the byte actually returned on a read, the ECC decode table across all codes and both chip-enable states, the write-enable gating, the interplay of mask and enable on the interrupt, and the register values read back after a soft reset.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        IDX_DATA  = 3'd0,
        IDX_MODE  = 3'd1,
        IDX_STAT  = 3'd2,
        IDX_IFLAG = 3'd3,
        IDX_IMASK = 3'd4,
        IDX_PULSE = 3'd5,
        IDX_SRST  = 3'd6,
        IDX_ECC   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic [1:0] ecc;
        logic       wren;
        logic       ce;
        logic       ale;
        logic       cle;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [2:0] {
        ECC_OFF   = 3'd0,
        ECC_WRITE = 3'd1,
        ECC_READ  = 3'd2,
        ECC_CLEAR = 3'd3,
        ECC_IDRD  = 3'd4
    } ecc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_DONE  = 2'd2
    } strobe_st_e;

    function automatic ecc_op_e decode_ecc(mode_t m);
        ecc_op_e op;
        op = ECC_OFF;
        if (m.ecc == 2'b11)
            op = ECC_CLEAR;
        else if (m.ce) begin
            case (m.ecc)
                2'b01:   op = ECC_WRITE;
                2'b10:   op = ECC_READ;
                default: op = ECC_OFF;
            endcase
        end else if (m.ecc == 2'b10)
            op = ECC_IDRD;
        return op;
    endfunction

endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync (
    input  logic clk,
    input  logic rst,
    input  logic rb_n_in,
    output logic ready_s,
    output logic change_p
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rb_n_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign ready_s  = s2;
    assign change_p = s2 ^ s3;
endmodule

// File: rtl/nfc_strobe_gen.sv
module nfc_strobe_gen
    import nfc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PULSE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_wr,
    input  logic               start_rd,
    input  logic [PULSE_W-1:0] width,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  io_in,
    output logic               we_n,
    output logic               re_n,
    output logic [DATA_W-1:0]  io_out,
    output logic               io_oe,
    output logic [DATA_W-1:0]  rdata,
    output logic               done
);
    strobe_st_e         st;
    logic [PULSE_W-1:0] cnt;
    logic               is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            is_wr  <= 1'b0;
            we_n   <= 1'b1;
            re_n   <= 1'b1;
            io_oe  <= 1'b0;
            io_out <= '0;
            rdata  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_wr || start_rd) begin
                        st     <= ST_PULSE;
                        cnt    <= '0;
                        is_wr  <= start_wr;
                        we_n   <= !start_wr;
                        re_n   <= start_wr;
                        io_oe  <= start_wr;
                        io_out <= wdata;
                    end
                end
                ST_PULSE: begin
                    if (cnt == width) begin
                        st   <= ST_DONE;
                        we_n <= 1'b1;
                        re_n <= 1'b1;
                        if (!is_wr)
                            rdata <= io_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st    <= ST_IDLE;
                    io_oe <= 1'b0;
                end
            endcase
        end
    end

    assign done = (st == ST_DONE);
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
    import nfc_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PULSE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_wait,
    output logic [DATA_W-1:0] nand_io_out,
    input  logic [DATA_W-1:0] nand_io_in,
    output logic              nand_io_oe,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    input  logic              nand_rb_n,
    output logic              irq,
    output logic [2:0]        ecc_op
);
    reg_idx_e           idx;
    mode_t              mode_q;
    logic               inten_q, flag_q, mask_q;
    logic [PULSE_W-1:0] pulse_q;
    logic               soft_rst, ctl_rst;
    logic               ready_s, rb_change, busy_s;
    logic               dw_hit, start_wr, start_rd, strobe_done;
    logic [DATA_W-1:0]  dw_rdata;

    assign idx      = reg_idx_e'(bus_addr);
    assign soft_rst = bus_sel && bus_wr && (idx == IDX_SRST) && bus_wdata[0];
    assign ctl_rst  = rst || soft_rst;

    nfc_rb_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .rb_n_in  (nand_rb_n),
        .ready_s  (ready_s),
        .change_p (rb_change)
    );
    assign busy_s = !ready_s;

    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            mode_q  <= '0;
            inten_q <= 1'b0;
            mask_q  <= 1'b0;
            pulse_q <= '0;
        end else if (bus_sel && bus_wr) begin
            case (idx)
                IDX_MODE:  mode_q  <= mode_t'(bus_wdata[MODE_W-1:0]);
                IDX_STAT:  inten_q <= bus_wdata[1];
                IDX_IMASK: mask_q  <= bus_wdata[0];
                IDX_PULSE: pulse_q <= bus_wdata[PULSE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (ctl_rst)
            flag_q <= 1'b0;
        else if (rb_change)
            flag_q <= 1'b1;
        else if (bus_sel && bus_wr && (idx == IDX_IFLAG) && bus_wdata[0])
            flag_q <= 1'b0;
    end

    assign dw_hit   = bus_sel && (idx == IDX_DATA);
    assign start_wr = dw_hit && bus_wr && mode_q.wren;
    assign start_rd = dw_hit && !bus_wr;

    nfc_strobe_gen #(
        .DATA_W  (DATA_W),
        .PULSE_W (PULSE_W)
    ) u_strobe (
        .clk      (clk),
        .rst      (ctl_rst),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .width    (pulse_q),
        .wdata    (bus_wdata),
        .io_in    (nand_io_in),
        .we_n     (nand_we_n),
        .re_n     (nand_re_n),
        .io_out   (nand_io_out),
        .io_oe    (nand_io_oe),
        .rdata    (dw_rdata),
        .done     (strobe_done)
    );

    assign bus_wait = (start_wr || start_rd) && !strobe_done;

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_DATA:  bus_rdata = dw_rdata;
            IDX_MODE:  bus_rdata[MODE_W-1:0] = mode_q;
            IDX_STAT:  bus_rdata[1:0] = {inten_q, busy_s};
            IDX_IFLAG: bus_rdata[0] = flag_q;
            IDX_IMASK: bus_rdata[0] = mask_q;
            IDX_PULSE: bus_rdata[PULSE_W-1:0] = pulse_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign nand_ce_n = !mode_q.ce;
    assign nand_cle  = mode_q.cle;
    assign nand_ale  = mode_q.ale;
    assign irq       = flag_q && mask_q && inten_q;
    assign ecc_op    = decode_ecc(mode_q);
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
    parameter int PULSE_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [2:0]         bus_addr,
    input logic [2:0]         wd_low,
    input logic               bus_wait,
    input logic               nand_we_n,
    input logic               nand_re_n,
    input logic               nand_ce_n,
    input logic               nand_cle,
    input logic               nand_ale,
    input logic               busy_s,
    input logic               flag_q,
    input logic               soft_rst,
    input logic [PULSE_W-1:0] pulse_q
);
    localparam int CW       = PULSE_W + 2;
    localparam int WAIT_MAX = (1 << PULSE_W) + 2;

    logic [CW-1:0] low_cnt, wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            wait_cnt <= '0;
        end else begin
            low_cnt  <= (!nand_we_n || !nand_re_n) ? low_cnt + 1'b1 : '0;
            wait_cnt <= bus_wait ? wait_cnt + 1'b1 : '0;
        end
    end

    a_r1_strobe_width: assert property (@(posedge clk) disable iff (rst)
        ($rose(nand_we_n) || $rose(nand_re_n)) |-> (low_cnt == CW'(pulse_q) + 1'b1));

    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    a_r6_wait_bounded: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= CW'(WAIT_MAX));

    a_r5_write_source: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_we_n) |-> $past(bus_sel && bus_wr && bus_addr == 3'd0));

    a_r3_latch_follow: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 3'd1) |=>
            (nand_cle == $past(wd_low[0]) && nand_ale == $past(wd_low[1])));

    a_r2_ce_follow: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 3'd1) |=> (nand_ce_n == !$past(wd_low[2])));

    a_r8_flag_on_change: assert property (@(posedge clk) disable iff (rst)
        ((busy_s != $past(busy_s)) && !soft_rst) |=> flag_q);

    a_r10_soft_idle: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (nand_ce_n && !nand_cle && !nand_ale && !flag_q));
endmodule

bind nand_bus_ctrl nfc_checker #(.PULSE_W(PULSE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wd_low    (bus_wdata[2:0]),
    .bus_wait  (bus_wait),
    .nand_we_n (nand_we_n),
    .nand_re_n (nand_re_n),
    .nand_ce_n (nand_ce_n),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .busy_s    (busy_s),
    .flag_q    (flag_q),
    .soft_rst  (soft_rst),
    .pulse_q   (pulse_q)
);

// File: tb/nand_bus_ctrl_test.sv
`timescale 1ns/1ps
module nand_bus_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       bus_wait;
    logic [7:0] nand_io_out, nand_io_in = '0;
    logic       nand_io_oe, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic       nand_rb_n = 1'b1;
    logic       irq;
    logic [2:0] ecc_op;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nand_bus_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
        .nand_io_out(nand_io_out), .nand_io_in(nand_io_in), .nand_io_oe(nand_io_oe),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n),
        .irq(irq), .ecc_op(ecc_op)
    );

    // vector: [20:17] pulse width, [16] write, [15:8] write byte, [7:0] flash byte
    localparam logic [20:0] VEC [0:6] = '{
        {4'd0,  1'b1, 8'hA5, 8'h00},
        {4'd0,  1'b0, 8'h00, 8'h3C},
        {4'd3,  1'b1, 8'h81, 8'h00},
        {4'd7,  1'b0, 8'h00, 8'h5A},
        {4'd15, 1'b1, 8'hFF, 8'h00},
        {4'd15, 1'b0, 8'h00, 8'hC3},
        {4'd1,  1'b0, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic data_acc(input logic wr, input logic [7:0] d, output logic [7:0] rd,
                            output int lows, output int waits, output logic io_ok);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = 3'd0; bus_wdata = d;
        lows = 0; waits = 0; io_ok = 1'b1;
        #1;
        while (bus_wait && waits < 100) begin
            waits++;
            @(negedge clk);
            #1;
            if (!nand_we_n || !nand_re_n) lows++;
            if (!nand_we_n && (!nand_io_oe || nand_io_out !== d)) io_ok = 1'b0;
        end
        rd = bus_rdata;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int lows, waits;
        logic io_ok;

        settle(3);
        rst = 1'b0;
        #1;
        // reset state (R2, R3, R1, R9)
        chk("R2 ce_n after reset", nand_ce_n, 1);
        chk("R3 cle/ale after reset", {nand_cle, nand_ale}, 0);
        chk("R1 strobes idle after reset", {nand_we_n, nand_re_n}, 2'b11);
        chk("R9 irq after reset", irq, 0);
        reg_rd(3'd1, rd); chk("R10 mode reset value", rd, 0);

        // strobe table (R1, R6)
        reg_wr(3'd1, 8'h0C);
        for (int v = 0; v < 7; v++) begin
            logic [3:0] w;
            w = VEC[v][20:17];
            reg_wr(3'd5, {4'd0, w});
            nand_io_in = VEC[v][7:0];
            data_acc(VEC[v][16], VEC[v][15:8], rd, lows, waits, io_ok);
            chk("R1 strobe low cycles", lows, w + 1);
            chk("R6 wait cycles", waits, w + 2);
            if (VEC[v][16]) chk("R6 write data on pins", io_ok, 1);
            else            chk("R6 read data captured", rd, VEC[v][7:0]);
        end

        // write gating (R5)
        reg_wr(3'd1, 8'h04);
        data_acc(1'b1, 8'h77, rd, lows, waits, io_ok);
        chk("R5 no strobe when write disabled", lows, 0);
        chk("R5 no wait when write disabled", waits, 0);

        // pins follow mode bits (R2, R3)
        reg_wr(3'd1, 8'h03); #1;
        chk("R3 cle and ale high", {nand_cle, nand_ale}, 2'b11);
        chk("R2 ce_n high when ce bit 0", nand_ce_n, 1);
        reg_wr(3'd1, 8'h06); #1;
        chk("R3 cle low ale high", {nand_cle, nand_ale}, 2'b01);
        chk("R2 ce_n low when ce bit 1", nand_ce_n, 0);

        // ECC decode (R4)
        reg_wr(3'd1, 8'h34); #1; chk("R4 code 11 ce1 clear", ecc_op, 3);
        reg_wr(3'd1, 8'h30); #1; chk("R4 code 11 ce0 clear", ecc_op, 3);
        reg_wr(3'd1, 8'h14); #1; chk("R4 code 01 ce1 write", ecc_op, 1);
        reg_wr(3'd1, 8'h24); #1; chk("R4 code 10 ce1 read", ecc_op, 2);
        reg_wr(3'd1, 8'h04); #1; chk("R4 code 00 ce1 off", ecc_op, 0);
        reg_wr(3'd1, 8'h20); #1; chk("R4 code 10 ce0 id read", ecc_op, 4);
        reg_wr(3'd1, 8'h10); #1; chk("R4 code 01 ce0 off", ecc_op, 0);

        // ECC code register (R11)
        reg_rd(3'd7, rd); chk("R11 ecc code reads zero", rd, 0);
        reg_rd(3'd6, rd); chk("R11 reset register reads zero", rd, 0);

        // ready/busy and interrupt (R7, R8, R9)
        reg_rd(3'd2, rd); chk("R7 ready status", rd, 0);
        reg_wr(3'd2, 8'h02);
        reg_wr(3'd4, 8'h01);
        nand_rb_n = 1'b0;
        settle(5); #1;
        reg_rd(3'd2, rd); chk("R7 busy status with enable", rd, 8'h03);
        reg_rd(3'd3, rd); chk("R8 flag set on falling rb", rd, 1);
        chk("R9 irq with mask and enable", irq, 1);
        reg_wr(3'd3, 8'h01); #1;
        reg_rd(3'd3, rd); chk("R8 flag cleared by write 1", rd, 0);
        chk("R9 irq low after clear", irq, 0);
        reg_wr(3'd4, 8'h00);
        nand_rb_n = 1'b1;
        settle(5); #1;
        reg_rd(3'd3, rd); chk("R8 flag set on rising rb", rd, 1);
        chk("R9 irq masked", irq, 0);
        reg_wr(3'd4, 8'h01); #1;
        chk("R9 irq unmasked", irq, 1);
        reg_wr(3'd2, 8'h00); #1;
        chk("R9 irq with enable off", irq, 0);

        // soft reset (R10)
        reg_wr(3'd2, 8'h02);
        reg_wr(3'd5, 8'h09);
        reg_wr(3'd1, 8'h07);
        reg_wr(3'd6, 8'h01); #1;
        reg_rd(3'd1, rd); chk("R10 mode cleared", rd, 0);
        reg_rd(3'd2, rd); chk("R10 enable cleared", rd, 0);
        reg_rd(3'd3, rd); chk("R10 flag cleared", rd, 0);
        reg_rd(3'd4, rd); chk("R10 mask cleared", rd, 0);
        reg_rd(3'd5, rd); chk("R10 pulse cleared", rd, 0);
        chk("R10 ce_n idle", nand_ce_n, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule